// File: doc/BRIEF.md
# Reset Cause and Soft Reset Request Register

A single 32-bit control and status register that records why the system last came out of reset and lets software ask for a new reset. Five bits at the top of the word carry meaning. Three of them are status flags that software clears by writing a one. Two of them are soft request bits that a written one sets. Writing one to a request bit also produces a reset request for the rest of the system.

The block tracks whether the next system reset counts as a power-on event. After power-up, the first system reset loads the register with only the power-on flag set. Every later system reset leaves the register unchanged. A soft power-on request re-arms this tracking, so the reset it causes is again treated as a power-on. A soft externally-initiated request leaves the tracking alone.

The register sits in the odd 32-bit word of an 8-byte slot. The even word reads as zero and ignores writes.

Top module: `rst_ctl_reg`

## Requirements
- R1: While rst_ni is low and after it rises, rdata_o reads 0 at the odd word and rst_req_o is 0.
- R2: The first sys_rst_i cycle after power-up, or after re-arming, loads the register with 0x80000000: only bit 31, the power-on flag, is set.
- R3: A sys_rst_i cycle when tracking is not re-armed leaves the register value unchanged.
- R4: Bits 26:0 of a write are discarded and always read as 0.
- R5: Writing one to bit 31, bit 28 or bit 27 clears that bit. Writing zero to any of them leaves it unchanged.
- R6: Writing one to bit 30 (soft power-on) or bit 29 (soft XIR) sets that bit. Writing zero leaves it unchanged.
- R7: A write with bit 30 set raises rst_req_o for exactly one cycle, in the cycle after the write, and re-arms tracking so the next sys_rst_i behaves as in R2.
- R8: A write with bit 29 set and bit 30 clear raises the same one-cycle rst_req_o pulse but does not re-arm tracking.
- R9: The register is selected when address bit 2 is 1. With address bit 2 at 0, rdata_o is 0 and writes have no effect.
- R10: A write in the same cycle as sys_rst_i is discarded: it changes no bit, produces no rst_req_o pulse and does not re-arm tracking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| sys_rst_i | input | 1 | System reset event, one cycle per reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Byte address within the 8-byte slot |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| rst_req_o | output | 1 | One-cycle reset request pulse |

## Verification
A software write and a system reset event can land in the same cycle. The bench provokes this twice. In the first case tracking is settled, so the reset should keep the register. In the second case a soft power-on has just re-armed tracking, so the reset should load the power-on value. A behavioural model judges both cases: it drops the write, expects no request pulse, and applies only the reset rule. Each result is then read back through the odd word and watched on rst_req_o.

// File: rtl/rst_ctl_pkg.sv
package rst_ctl_pkg;
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_SOFT_POR = 2'd1,
    REQ_SOFT_XIR = 2'd2
  } req_kind_e;
endpackage

// File: rtl/rst_ctl_decode.sv
module rst_ctl_decode
  import rst_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned SEL_BIT = 2
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              sel_o,
  output logic              hit_o,
  output logic [DATA_W-1:0] wval_o,
  output req_kind_e         kind_o
);
  localparam int unsigned P_SPOR = DATA_W - 2;
  localparam int unsigned P_SXIR = DATA_W - 3;
  localparam int unsigned N_IMPL = 5;
  localparam logic [DATA_W-1:0] IMPL_MASK = {{N_IMPL{1'b1}}, {(DATA_W-N_IMPL){1'b0}}};

  assign sel_o  = addr_i[SEL_BIT];
  assign hit_o  = we_i & sel_o;
  assign wval_o = wdata_i & IMPL_MASK;

  // soft power-on outranks soft XIR
  always_comb begin
    if (wval_o[P_SPOR])      kind_o = REQ_SOFT_POR;
    else if (wval_o[P_SXIR]) kind_o = REQ_SOFT_XIR;
    else                     kind_o = REQ_NONE;
  end
endmodule

// File: rtl/rst_ctl_status.sv
module rst_ctl_status
  import rst_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] wval_i,
  input  req_kind_e         kind_i,
  output logic [DATA_W-1:0] stat_o,
  output logic              accept_o
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam int unsigned P_POR  = DATA_W - 1;
  localparam int unsigned P_SPOR = DATA_W - 2;
  localparam int unsigned P_SXIR = DATA_W - 3;
  localparam int unsigned P_BPOR = DATA_W - 4;
  localparam int unsigned P_BXIR = DATA_W - 5;
  localparam logic [DATA_W-1:0] W1C_MASK = (ONE << P_POR) | (ONE << P_BPOR) | (ONE << P_BXIR);
  localparam logic [DATA_W-1:0] W1S_MASK = (ONE << P_SPOR) | (ONE << P_SXIR);
  localparam logic [DATA_W-1:0] POR_VAL  = ONE << P_POR;

  logic [DATA_W-1:0] stat_q;
  logic              armed_q;  // next system reset counts as power-on

  assign accept_o = hit_i & ~sys_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      armed_q <= 1'b1;
    end else if (sys_rst_i) begin
      if (armed_q) begin
        stat_q  <= POR_VAL;
        armed_q <= 1'b0;
      end
    end else if (accept_o) begin
      stat_q <= (stat_q & ~(wval_i & W1C_MASK)) | (wval_i & W1S_MASK);
      if (kind_i == REQ_SOFT_POR) armed_q <= 1'b1;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/rst_ctl_req.sv
module rst_ctl_req
  import rst_ctl_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      accept_i,
  input  req_kind_e kind_i,
  output logic      pulse_o
);
  logic pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= accept_i & (kind_i != REQ_NONE);
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/rst_ctl_reg.sv
module rst_ctl_reg
  import rst_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o
);
  localparam int unsigned SEL_BIT = 2;

  logic              sel, hit, accept;
  logic [DATA_W-1:0] wval, stat_q;
  req_kind_e         kind;

  rst_ctl_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT)) u_decode (
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .sel_o(sel), .hit_o(hit), .wval_o(wval), .kind_o(kind)
  );

  rst_ctl_status #(.DATA_W(DATA_W)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .sys_rst_i(sys_rst_i),
    .hit_i(hit), .wval_i(wval), .kind_i(kind),
    .stat_o(stat_q), .accept_o(accept)
  );

  rst_ctl_req u_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .accept_i(accept), .kind_i(kind),
    .pulse_o(rst_req_o)
  );

  assign rdata_o = sel ? stat_q : '0;
endmodule

// File: rtl/rst_ctl_reg_chk.sv
module rst_ctl_reg_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sys_rst_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rst_req_o,
  input logic [DATA_W-1:0] stat_q
);
  assert_unused_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q[DATA_W-6:0] == '0);

  assert_even_word_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i[2] |-> rdata_o == '0);

  assert_even_write_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_i[2] && !sys_rst_i) |=> $stable(stat_q) && !rst_req_o);

  assert_pulse_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);

  assert_collision_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i |=> !rst_req_o);

  assert_soft_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[2] && !sys_rst_i && wdata_i[DATA_W-2]) |=> stat_q[DATA_W-2] && rst_req_o);

  assert_w1c_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[2] && !sys_rst_i && wdata_i[DATA_W-1]) |=> !stat_q[DATA_W-1]);
endmodule

bind rst_ctl_reg rst_ctl_reg_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sys_rst_i(sys_rst_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .rst_req_o(rst_req_o), .stat_q(stat_q)
);

// File: tb/test_rst_ctl_reg.sv
`timescale 1ns/1ps
module test_rst_ctl_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sys_rst = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd4;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string cur = "R1";

  // behavioural reference
  logic [31:0] m_reg;
  bit          m_armed;
  bit          m_req;

  always #10 clk = ~clk;

  rst_ctl_reg i_rst_ctl_reg (
    .clk_i(clk), .rst_ni(rst_n), .sys_rst_i(sys_rst), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(req)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 0; m_armed = 1; m_req = 0;
    end else begin
      bit nreq;
      nreq = 0;
      if (sys_rst) begin
        if (m_armed) begin m_reg = 32'h8000_0000; m_armed = 0; end
      end else if (we && addr[2]) begin
        logic [31:0] v;
        v = wdata & 32'hF800_0000;
        m_reg = (m_reg & ~(v & 32'h9800_0000)) | (v & 32'h6000_0000);
        if (v[30]) begin m_armed = 1; nreq = 1; end
        else if (v[29]) nreq = 1;
      end
      m_req = nreq;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) if (!done) begin
    check({cur, " rdata"}, rdata, addr[2] ? m_reg : 32'h0);
    check({cur, " req"}, {31'h0, req}, {31'h0, m_req});
  end

  task automatic step(input bit s, input bit w, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    #1;
    sys_rst = s; we = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    sys_rst = 0; we = 0; addr = 3'd4; wdata = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    cur = "R1";
    idle(3);
    check("R1 reset rdata", rdata, 32'h0);
    check("R1 reset req", {31'h0, req}, 32'h0);
    @(negedge clk); rst_n = 1;
    idle(2);
    check("R1 after release", rdata, 32'h0);

    cur = "R2";  step(1, 0, 3'd4, 0); idle(2);
    check("R2 power-on value", rdata, 32'h8000_0000);

    cur = "R9";  step(0, 1, 3'd0, 32'hFFFF_FFFF); idle(2);
    check("R9 even write ignored", rdata, 32'h8000_0000);
    step(0, 0, 3'd0, 0);

    cur = "R8";  step(0, 1, 3'd4, 32'h27FF_FFFF); idle(2);
    check("R4 low bits dropped", rdata, 32'hA000_0000);
    step(1, 0, 3'd4, 0); idle(2);
    check("R3 reset keeps value", rdata, 32'hA000_0000);

    cur = "R5";  step(0, 1, 3'd4, 32'h9800_0000); idle(2);
    check("R5 w1c bit31", rdata, 32'h2000_0000);
    cur = "R6";  step(0, 1, 3'd4, 32'h0); idle(2);
    check("R6 zero write keeps", rdata, 32'h2000_0000);

    cur = "R7";  step(0, 1, 3'd4, 32'h4000_0000); idle(2);
    check("R7 soft por set", rdata, 32'h6000_0000);
    step(1, 0, 3'd4, 0); idle(2);
    check("R7 rearmed reset", rdata, 32'h8000_0000);

    cur = "R10"; step(1, 1, 3'd4, 32'h6000_0000); idle(2);
    check("R10 collision settled", rdata, 32'h8000_0000);
    step(0, 1, 3'd4, 32'h4000_0000); idle(1);
    step(1, 1, 3'd4, 32'h2000_0000); idle(2);
    check("R10 collision rearmed", rdata, 32'h8000_0000);

    cur = "R3";  step(1, 0, 3'd4, 0); idle(2);
    check("R3 later reset keeps", rdata, 32'h8000_0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule